// File: doc/BRIEF.md
# Audio DAC serial clock generator

This block drives a stereo audio DAC from a single fast master clock. It produces a system clock at 128 times the sample rate, a bit clock at 32 times the sample rate, a word clock at the sample rate, and a serial data line that carries one 16-bit left sample and one 16-bit right sample per frame. All three clocks are derived from one phase counter, so their edges keep a fixed relation and never drift against each other.

The master clock is divided by a fractional accumulator whose ratio DIV_DEN/DIV_NUM sets the rate of half-periods of the system clock. The nominal use is an 8 kHz sample rate, which gives a 1.024 MHz system clock and a 256 kHz bit clock; from a 50 MHz master this is a ratio of 3125/128. Any jitter from a non-integer ratio lands on individual system-clock half-periods. The bit and word clocks always advance by whole system-clock cycles.

A new stereo pair is offered on a valid/ready handshake. The block accepts it during the last system-clock cycle of the right word and sends it in the following frame. When no pair is offered, the previous pair is sent again and the clocks keep running.

Top module: `dacclk_gen`

## Requirements
- R1: Every word-clock period contains exactly 128 rising system-clock edges and 32 rising bit-clock edges.
- R2: Every bit-clock period spans four system-clock cycles. The system clock rises twice while the bit clock is low and twice while it is high.
- R3: Each system-clock half-period lasts either floor(DIV_DEN/DIV_NUM) or ceil(DIV_DEN/DIV_NUM) master-clock cycles. With 128/3125 this is 24 or 25 cycles, and every word-clock period is exactly 6250 master cycles.
- R4: The word clock is high for the 16 left bits and low for the 16 right bits. The left word comes first in a frame. The word clock changes only together with a falling bit-clock edge.
- R5: Each word is 16 bits long and is sent most significant bit first, one bit per bit-clock period. The data line changes only while the bit clock is low, so it is stable at each rising bit-clock edge.
- R6: The ready output is high only in the last system-clock cycle of the right word, where the bit clock is high and the word clock is low. It drops after one accepted pair. A pair accepted there (left on in_left_i, right on in_right_i) is sent as the next frame.
- R7: If no pair is accepted before a frame starts, that frame repeats the previous pair.
- R8: During and after reset, the system-clock, bit-clock, word-clock, data and ready outputs are low. The first frame starts with the word clock high and the left word, and it carries zero samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | A stereo pair is offered |
| in_left_i | input | 16 | Left-channel sample of the offered pair |
| in_right_i | input | 16 | Right-channel sample of the offered pair |
| in_ready_o | output | 1 | Block takes the offered pair on this cycle |
| sysclk_o | output | 1 | System clock, 128 x sample rate |
| bitclk_o | output | 1 | Bit clock, 32 x sample rate |
| wordclk_o | output | 1 | Word clock, sample rate, high for left |
| sdata_o | output | 1 | Serial sample data, MSB first |

## Verification
The assertions assume that DIV_NUM does not exceed DIV_DEN. They also assume that the valid flag and the sample inputs change only in step with the master clock. The no-back-to-back tick check applies only when the ratio is at least two. The stimulus drives all inputs one time step after a rising edge. It holds each offered pair unchanged until ready takes it, and it sometimes withholds valid for longer than a frame, so that repeated frames occur. The divider is run at the 3125/128 ratio, which exercises the uneven 24/25-cycle half-periods.

// File: rtl/dacclk_pkg.sv
package dacclk_pkg;

  // Width of one channel sample; must be a power of two.
  localparam int unsigned SAMPLE_W = 16;

  // Half-periods of the system clock in one frame: two channel words,
  // each bit spans four system-clock cycles of two half-periods.
  localparam int unsigned FRAME_HALVES = 16 * SAMPLE_W;
  localparam int unsigned PHASE_W      = $clog2(FRAME_HALVES);

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
  } stereo_pair_t;

endpackage

// File: rtl/dacclk_frac_div.sv
module dacclk_frac_div #(
  parameter int unsigned DIV_NUM = 128,
  parameter int unsigned DIV_DEN = 3125
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int unsigned ACC_W = $clog2(DIV_DEN + DIV_NUM) + 1;
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(DIV_NUM);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(DIV_DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             tick_q;

  assign acc_sum = acc_q + STEP;
  assign tick_o  = tick_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (acc_sum >= LIMIT) begin
      acc_q  <= acc_sum - LIMIT;
      tick_q <= 1'b1;
    end else begin
      acc_q  <= acc_sum;
      tick_q <= 1'b0;
    end
  end

  // R3: the residue always stays below the denominator
  a_r3_acc_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q < LIMIT);

  generate
    if (2 * DIV_NUM <= DIV_DEN) begin : g_spacing
      // R3: with a ratio of two or more, ticks are never adjacent
      a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/dacclk_phase.sv
module dacclk_phase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_q + 1'b1;

  // Reset to the last phase so that the first tick opens a frame.
  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '1;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end

  // R1: the phase advances by exactly one step per tick
  a_r1_phase_step: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R1: without a tick the phase holds
  a_r1_phase_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/dacclk_sample_hold.sv
module dacclk_sample_hold
  import dacclk_pkg::*;
#(
  parameter int unsigned CNT_W = PHASE_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                tick_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [CNT_W-1:0]    cnt_nxt_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output stereo_pair_t        pair_o
);

  // The last system-clock cycle of a frame covers the final two phases.
  localparam logic [CNT_W-1:0] OPEN_AT = ~CNT_W'(1);

  logic         win_q;
  logic         taken_q;
  logic         accept;
  stereo_pair_t pair_q;

  // No acceptance on a tick cycle: the frame boundary reads a steady pair.
  assign ready_o = win_q & ~taken_q & ~tick_i;
  assign accept  = valid_i & ready_o;
  assign pair_o  = pair_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q   <= 1'b0;
      taken_q <= 1'b0;
      pair_q  <= '0;
    end else begin
      if (tick_i) begin
        win_q <= &cnt_nxt_i[CNT_W-1:1];
        if (cnt_nxt_i == OPEN_AT) taken_q <= 1'b0;
      end
      if (accept) begin
        taken_q     <= 1'b1;
        pair_q.left  <= left_i;
        pair_q.right <= right_i;
      end
    end
  end

  // R6: ready only inside the closing system-clock cycle of the frame
  a_r6_ready_window: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |-> cnt_i >= OPEN_AT);

  // R6: at most one pair per window
  a_r6_single_accept: assert property (@(posedge clk_i) disable iff (rst_i)
    accept |=> !ready_o);

  // R7: the held pair changes only on an accepted handshake
  a_r7_pair_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !accept |=> $stable(pair_q));

endmodule

// File: rtl/dacclk_serializer.sv
module dacclk_serializer
  import dacclk_pkg::*;
#(
  parameter int unsigned CNT_W = PHASE_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  stereo_pair_t     pair_i,
  output logic             sysclk_o,
  output logic             bitclk_o,
  output logic             wordclk_o,
  output logic             sdata_o
);

  localparam int unsigned IDX_W = CNT_W - 4;

  stereo_pair_t     frame_q;
  stereo_pair_t     src;
  logic [IDX_W-1:0] bit_sel;
  logic             frame_start;
  logic             bit_start;
  logic             next_bit;
  logic             sys_q, bit_q, word_q, data_q;

  assign frame_start = (cnt_nxt_i == '0);
  assign bit_start   = (cnt_nxt_i[2:0] == 3'b000);
  // First bit of a frame is taken straight from the incoming pair.
  assign src         = frame_start ? pair_i : frame_q;
  // MSB first: bit position is the complement of the bit index.
  assign bit_sel     = ~cnt_nxt_i[CNT_W-2:3];
  assign next_bit    = cnt_nxt_i[CNT_W-1] ? src.right[bit_sel] : src.left[bit_sel];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frame_q <= '0;
      sys_q   <= 1'b0;
      bit_q   <= 1'b0;
      word_q  <= 1'b0;
      data_q  <= 1'b0;
    end else if (tick_i) begin
      sys_q  <= cnt_nxt_i[0];
      bit_q  <= cnt_nxt_i[2];
      word_q <= ~cnt_nxt_i[CNT_W-1];
      if (frame_start) frame_q <= pair_i;
      if (bit_start)   data_q  <= next_bit;
    end
  end

  assign sysclk_o  = sys_q;
  assign bitclk_o  = bit_q;
  assign wordclk_o = word_q;
  assign sdata_o   = data_q;

  // R5: data moves only while the bit clock is low
  a_r5_data_bclk_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(data_q) |-> !bit_q);

  // R4: word clock moves only while the bit clock is low
  a_r4_word_bclk_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(word_q) |-> !bit_q);

  // R2: the bit clock rises on a falling system-clock edge
  a_r2_bclk_rise_phase: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(bit_q) |-> !sys_q);

  // R3: outputs move only on divider ticks
  a_r3_outputs_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable({sys_q, bit_q, word_q, data_q}));

endmodule

// File: rtl/dacclk_gen.sv
module dacclk_gen
  import dacclk_pkg::*;
#(
  parameter int unsigned DIV_NUM = 128,
  parameter int unsigned DIV_DEN = 3125
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                in_ready_o,
  output logic                sysclk_o,
  output logic                bitclk_o,
  output logic                wordclk_o,
  output logic                sdata_o
);

  logic               tick;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phase_nxt;
  stereo_pair_t       pair;

  dacclk_frac_div #(
    .DIV_NUM (DIV_NUM),
    .DIV_DEN (DIV_DEN)
  ) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_o (tick)
  );

  dacclk_phase #(
    .CNT_W (PHASE_W)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick),
    .cnt_o     (phase),
    .cnt_nxt_o (phase_nxt)
  );

  dacclk_sample_hold #(
    .CNT_W (PHASE_W)
  ) u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick),
    .cnt_i     (phase),
    .cnt_nxt_i (phase_nxt),
    .valid_i   (in_valid_i),
    .left_i    (in_left_i),
    .right_i   (in_right_i),
    .ready_o   (in_ready_o),
    .pair_o    (pair)
  );

  dacclk_serializer #(
    .CNT_W (PHASE_W)
  ) u_ser (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick),
    .cnt_nxt_i (phase_nxt),
    .pair_i    (pair),
    .sysclk_o  (sysclk_o),
    .bitclk_o  (bitclk_o),
    .wordclk_o (wordclk_o),
    .sdata_o   (sdata_o)
  );

endmodule

// File: tb/dacclk_gen_tb.sv
module dacclk_gen_tb;

  localparam int FRAME_CYC  = 6250;
  localparam int RUN_FRAMES = 20;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [15:0] left = '0, right = '0;
  logic        ready, sclk, bclk, lrclk, sdata;

  always #10 clk = ~clk;

  dacclk_gen #(.DIV_NUM(128), .DIV_DEN(3125)) u_dut (
    .clk_i(clk), .rst_i(rst), .in_valid_i(valid), .in_left_i(left),
    .in_right_i(right), .in_ready_o(ready), .sysclk_o(sclk),
    .bitclk_o(bclk), .wordclk_o(lrclk), .sdata_o(sdata));

  int n_tests = 0, n_fail = 0;
  int hs_cnt = 0, frames = 0, total = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Directed pairs for the first accepts, random afterwards.
  function automatic logic [31:0] make_pair(input int idx);
    case (idx)
      0: return 32'h8000_7FFF;
      1: return 32'hFFFF_0000;
      2: return 32'hAAAA_5555;
      3: return 32'h0001_8001;
      default: return $urandom;
    endcase
  endfunction

  // Monitor state
  logic p_sclk = 0, p_bclk = 0, p_lrclk = 0, p_sdata = 0;
  int   half_len = 0, sclk_edges = 0, sr_bit = 0, lo_n = 0, hi_n = 0;
  int   sr_frame = 0, br_frame = 0, bclk_rises = 0, cyc_frame = 0;
  int   lbits = 0, rbits = 0, acc_frame = 0;
  bit   from_acc = 0;
  logic [15:0] lcap = '0, rcap = '0, exp_l = '0, exp_r = '0, nxt_l = '0, nxt_r = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc_frame++;
      if (sclk != p_sclk) begin
        if (sclk_edges > 0)
          chk(half_len == 24 || half_len == 25, "R3 sysclk half-period", half_len, 24);
        sclk_edges++;
        half_len = 1;
      end else half_len++;
      if (sclk && !p_sclk) begin
        sr_bit++; sr_frame++;
        if (bclk) hi_n++; else lo_n++;
      end
      if (sdata != p_sdata) chk(!bclk, "R5 data moved with bitclk high", bclk, 0);
      if (lrclk != p_lrclk) chk(!bclk, "R4 wordclk moved with bitclk high", bclk, 0);
      if (bclk && !p_bclk) begin
        if (bclk_rises > 0) begin
          chk(sr_bit == 4, "R2 sysclk cycles per bit", sr_bit, 4);
          chk(lo_n == 2 && hi_n == 2, "R2 low/high split", lo_n * 16 + hi_n, 8'h22);
        end
        bclk_rises++; br_frame++;
        sr_bit = 0; lo_n = 0; hi_n = 0;
        if (lrclk) begin lcap = {lcap[14:0], sdata}; lbits++; end
        else begin rcap = {rcap[14:0], sdata}; rbits++; end
      end
      if (ready)
        chk(!lrclk && bclk && rbits == 16, "R6 ready outside window", rbits, 16);
      if (valid && ready) begin
        chk(acc_frame == 0, "R6 second accept in one window", acc_frame, 0);
        acc_frame++;
        nxt_l = left; nxt_r = right;
        hs_cnt++;
      end
      if (!lrclk && p_lrclk) begin
        chk(lbits == 16, "R5 left bit count", lbits, 16);
        chk(lcap == exp_l, from_acc ? "R6 left word" : "R7 repeated left word", lcap, exp_l);
        lbits = 0;
      end
      if (lrclk && !p_lrclk) begin
        if (frames == 0) begin
          chk(bclk_rises == 0 && lbits == 0 && rbits == 0, "R8 first frame starts left",
              bclk_rises, 0);
        end else begin
          chk(rbits == 16, "R5 right bit count", rbits, 16);
          chk(rcap == exp_r, from_acc ? "R6 right word" : "R7 repeated right word", rcap, exp_r);
          chk(sr_frame == 128, "R1 sysclk rises per frame", sr_frame, 128);
          chk(br_frame == 32, "R1 bitclk rises per frame", br_frame, 32);
          chk(cyc_frame == FRAME_CYC, "R3 master cycles per frame", cyc_frame, FRAME_CYC);
        end
        frames++;
        from_acc = (acc_frame != 0);
        acc_frame = 0;
        exp_l = nxt_l; exp_r = nxt_r;
        sr_frame = 0; br_frame = 0; cyc_frame = 0; rbits = 0;
      end
      p_sclk = sclk; p_bclk = bclk; p_lrclk = lrclk; p_sdata = sdata;
    end
  end

  // Stimulus
  initial begin
    int seen = 0;
    int gap = 0;
    logic [31:0] pr;
    void'($urandom(32'd20240611));
    repeat (5) begin
      @(negedge clk);
      chk({sclk, bclk, lrclk, sdata, ready} == 5'b0, "R8 outputs low in reset",
          {sclk, bclk, lrclk, sdata, ready}, 0);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk({sclk, bclk, lrclk, sdata, ready} == 5'b0, "R8 outputs low after reset",
        {sclk, bclk, lrclk, sdata, ready}, 0);
    pr = make_pair(0);
    left = pr[31:16]; right = pr[15:0]; valid = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (hs_cnt != seen) begin
        seen = hs_cnt;
        pr = make_pair(seen);
        left = pr[31:16]; right = pr[15:0];
        if (seen == 2) begin
          valid = 1'b0; gap = 14000;
        end else if ($urandom_range(0, 3) == 0) begin
          valid = 1'b0; gap = $urandom_range(7000, 9000);
        end else valid = 1'b1;
      end else if (!valid) begin
        if (gap > 0) gap--;
        else valid = 1'b1;
      end
    end
  end

  // Run length and watchdog
  initial begin
    forever begin
      @(posedge clk);
      total++;
      if (frames >= RUN_FRAMES) begin
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
      if (total >= WATCHDOG) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d frames expected %0d", frames, RUN_FRAMES);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

endmodule